// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches up to 32 external interrupt pins and turns the activity on each one into a latched event. Each pin is first brought into the block clock domain by a two-stage synchroniser. A per-line sense field then chooses how the line is judged: active-low level, active-high level, falling edge, rising edge, or both edges. A matching condition sets that line's bit in a detect register, and software clears the bit by writing a one to it.

A per-line enable mask passes the latched events on. The ANDed result can be read as the request status, and it is ORed into a single interrupt output. The enable mask is never written directly. One register sets enable bits, another clears them, and reading the clear register returns the mask.

The enable and request registers appear in a small window of three words. That window is repeated at a 16-byte stride, once for each processor view, and every copy shares the same state. A monitor register returns the synchronised level of every pin. Software reaches all registers through a simple word-wide bus. A read returns its data one cycle after it is issued.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset, every detect bit, enable bit and sense field is 0, `irq_o` is low and `bus_rdata` is 0.
- R2: The sense field of line n lives at byte address 0x180 + 4*n and is held in data bits [5:0]. A write stores bits [5:0] only, and a read returns those six bits with bits [31:6] reading as 0.
- R3: Sense code 0x08 catches rising edges, 0x04 falling edges and 0x0C both edges. Each qualifying transition sets the detect bit exactly once, on the third rising clock edge after the pin changes (two synchroniser stages plus the latch). A transition of the opposite direction sets nothing.
- R4: Sense code 0x02 (high level) and 0x01 (low level) set the detect bit on every cycle in which the synchronised pin is at the active level. A clear therefore only holds once the pin has gone inactive.
- R5: A sense field whose bits [3:0] are all 0 never sets the detect bit, whatever the pin does. Bits [5:4] are stored but have no effect.
- R6: The detect register at 0x100 reads one bit per line. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If a clear and a new event for the same bit land in the same cycle, the bit stays set.
- R7: Writing 1s at window offset 0x08 sets the matching enable bits. Writing 1s at window offset 0x04 clears them. Reading offset 0x04 returns the enable mask, and offset 0x08 reads as 0.
- R8: Window offset 0x00 reads the detect bits ANDed with the enable mask. `irq_o` is high exactly when that value is nonzero.
- R9: The window at byte address w*0x10 behaves identically for every w below `NUM_WIN`, and all copies share one enable mask and one detect register.
- R10: The register at 0x104 returns the synchronised level of each pin, bit n for pin n.
- R11: A read returns its data on `bus_rdata` in the cycle after it is issued. Unmapped or unaligned addresses read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pins_i | input | NUM_LINES | Asynchronous external interrupt pins |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two operations can land on one detect bit in the same cycle: a software write-one-to-clear and a freshly detected event. The bench forces this collision for a rising edge. It times the clear write so that it is captured on exactly the clock edge where the synchronised edge sets the bit, and it expects the bit to read back as 1. A second pass moves the write one cycle later and expects 0.

The same collision happens naturally with a held active-high level, where every clear meets a new event. In that case the bit must read back as set until the pin is released.

// File: rtl/eisc_pkg.sv
// Package: shared constants and types for the external interrupt sense controller.
// Assumes a 12-bit byte address space and word-aligned accesses.
package eisc_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int SENSE_W = 6;   // stored sense field width
    localparam int MODE_W  = 4;   // sense bits that carry meaning

    // Bit positions inside the sense field
    localparam int SB_LOW  = 0;
    localparam int SB_HIGH = 1;
    localparam int SB_FALL = 2;
    localparam int SB_RISE = 3;

    // Fixed register addresses
    localparam logic [ADDR_W-1:0] ADR_DETECT  = 12'h100;
    localparam logic [ADDR_W-1:0] ADR_MONITOR = 12'h104;
    localparam logic [ADDR_W-1:0] ADR_CFG     = 12'h180;

    // Register selected inside a per-processor window
    typedef enum logic [1:0] {
        WREG_REQ  = 2'd0,
        WREG_EN   = 2'd1,
        WREG_SET  = 2'd2,
        WREG_NONE = 2'd3
    } win_reg_e;

endpackage

// File: rtl/eisc_sync.sv
// Module: two-stage pin synchroniser plus a one-cycle-delayed copy that
// serves as the edge reference. Assumes pins are fully asynchronous.
module eisc_sync #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pins_i,
    output logic [NUM_LINES-1:0] lvl_o,
    output logic [NUM_LINES-1:0] prev_o
);

    logic [NUM_LINES-1:0] stage1_q;
    logic [NUM_LINES-1:0] stage2_q;
    logic [NUM_LINES-1:0] prev_q;

    // Capture pins through two flops, then keep last cycle's synchronised value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pins_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign lvl_o  = stage2_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/eisc_detect.sv
// Module: per-line event decoder and detect latch. A line's event is the OR
// of its enabled sense conditions. The latch is set by an event and cleared
// by a write-one mask, and a set wins over a clear in the same cycle.
// Assumes lvl_i/prev_i come from the synchroniser.
module eisc_detect
    import eisc_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        lvl_i,
    input  logic [NUM_LINES-1:0]        prev_i,
    input  logic [NUM_LINES*MODE_W-1:0] mode_i,
    input  logic [NUM_LINES-1:0]        clr_i,
    output logic [NUM_LINES-1:0]        det_o
);

    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] det_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [MODE_W-1:0] m;
        assign m = mode_i[i*MODE_W +: MODE_W];

        // Combine level and edge conditions selected for this line
        assign evt[i] = (m[SB_LOW]  & ~lvl_i[i])
                      | (m[SB_HIGH] &  lvl_i[i])
                      | (m[SB_FALL] &  prev_i[i] & ~lvl_i[i])
                      | (m[SB_RISE] & ~prev_i[i] &  lvl_i[i]);

        AST_DET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(det_q[i]) |-> $past(evt[i])) else $error("detect set without event"); // R3
        AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n) $past(evt[i]) |-> det_q[i]) else $error("event lost"); // R6
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) ($past(clr_i[i]) && !$past(evt[i])) |-> !det_q[i]) else $error("clear ignored"); // R6
        AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (m == '0) |-> !evt[i]) else $error("event with sense off"); // R5
    end

    // Latch events; clear by mask unless a new event arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= (det_q & ~clr_i) | evt;
        end
    end

    assign det_o = det_q;

endmodule

// File: rtl/eisc_regs.sv
// Module: bus decode, sense configuration store, enable mask and registered
// read path. Assumes one-cycle bus strobes and word-aligned addresses;
// anything else is treated as unmapped.
module eisc_regs
    import eisc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_WIN   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_LINES-1:0]        det_i,
    input  logic [NUM_LINES-1:0]        lvl_i,
    output logic [NUM_LINES*MODE_W-1:0] mode_o,
    output logic [NUM_LINES-1:0]        en_o,
    output logic [NUM_LINES-1:0]        clr_o
);

    localparam int IDX_W = 5;

    logic                 aligned;
    logic                 win_hit;
    logic                 det_hit;
    logic                 mon_hit;
    logic                 cfg_hit;
    logic [IDX_W-1:0]     cfg_idx;
    win_reg_e             wreg;
    logic                 wr_stb;
    logic [NUM_LINES-1:0] set_mask;
    logic [NUM_LINES-1:0] off_mask;
    logic [NUM_LINES-1:0] en_q;
    logic [SENSE_W-1:0]   cfg_q [NUM_LINES];
    logic [DATA_W-1:0]    rd_val;
    logic [DATA_W-1:0]    rdata_q;

    // Address decode into register classes
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        win_hit = aligned && (bus_addr[ADDR_W-1:8] == '0)
                  && (int'(bus_addr[7:4]) < NUM_WIN);
        det_hit = (bus_addr == ADR_DETECT);
        mon_hit = (bus_addr == ADR_MONITOR);
        cfg_idx = bus_addr[IDX_W+1:2];
        cfg_hit = aligned && (bus_addr[ADDR_W-1:7] == ADR_CFG[ADDR_W-1:7])
                  && (int'(cfg_idx) < NUM_LINES);
        unique case (bus_addr[3:2])
            2'd0:    wreg = WREG_REQ;
            2'd1:    wreg = WREG_EN;
            2'd2:    wreg = WREG_SET;
            default: wreg = WREG_NONE;
        endcase
    end

    // Write strobes turned into per-line masks
    always_comb begin
        wr_stb   = bus_sel && bus_wr;
        set_mask = (wr_stb && win_hit && wreg == WREG_SET) ? bus_wdata[NUM_LINES-1:0] : '0;
        off_mask = (wr_stb && win_hit && wreg == WREG_EN)  ? bus_wdata[NUM_LINES-1:0] : '0;
        clr_o    = (wr_stb && det_hit) ? bus_wdata[NUM_LINES-1:0] : '0;
    end

    // Enable mask: set-by-one and clear-by-one only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | set_mask) & ~off_mask;
        end
    end

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (|set_mask) |=> ((en_q & $past(set_mask)) == $past(set_mask))) else $error("enable set lost"); // R7
    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (|off_mask) |=> ((en_q & $past(off_mask)) == '0)) else $error("enable clear lost"); // R7

    // Per-line sense field storage, low six bits of the write only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) cfg_q[i] <= '0;
        end else if (wr_stb && cfg_hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (int'(cfg_idx) == i) cfg_q[i] <= bus_wdata[SENSE_W-1:0];
            end
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_mode
        assign mode_o[i*MODE_W +: MODE_W] = cfg_q[i][MODE_W-1:0];
    end

    // Read data selection
    always_comb begin
        rd_val = '0;
        if (win_hit) begin
            case (wreg)
                WREG_REQ: rd_val[NUM_LINES-1:0] = det_i & en_q;
                WREG_EN:  rd_val[NUM_LINES-1:0] = en_q;
                default:  rd_val = '0;
            endcase
        end else if (det_hit) begin
            rd_val[NUM_LINES-1:0] = det_i;
        end else if (mon_hit) begin
            rd_val[NUM_LINES-1:0] = lvl_i;
        end else if (cfg_hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (int'(cfg_idx) == i) rd_val[SENSE_W-1:0] = cfg_q[i];
            end
        end
    end

    // Register read data one cycle after a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_sel && !bus_wr) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;
    assign en_o      = en_q;

endmodule

// File: rtl/ext_irq_sense_ctrl.sv
// Module: top of the external interrupt sense controller. Chains the
// synchroniser, detect latch and register block, and ORs the enabled
// detect bits into irq_o. Assumes NUM_LINES between 1 and 32.
module ext_irq_sense_ctrl
    import eisc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_WIN   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pins_i,
    output logic                 irq_o
);

    logic [NUM_LINES-1:0]        lvl;
    logic [NUM_LINES-1:0]        prev;
    logic [NUM_LINES-1:0]        det;
    logic [NUM_LINES-1:0]        en;
    logic [NUM_LINES-1:0]        clr;
    logic [NUM_LINES*MODE_W-1:0] mode;

    eisc_sync #(.NUM_LINES(NUM_LINES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    eisc_detect #(.NUM_LINES(NUM_LINES)) detect_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .prev_i (prev),
        .mode_i (mode),
        .clr_i  (clr),
        .det_o  (det)
    );

    eisc_regs #(.NUM_LINES(NUM_LINES), .NUM_WIN(NUM_WIN)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .det_i     (det),
        .lvl_i     (lvl),
        .mode_o    (mode),
        .en_o      (en),
        .clr_o     (clr)
    );

    // Combined request: any enabled latched event
    assign irq_o = |(det & en);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (|en)) else $error("irq without enable"); // R8
    AST_IRQ_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (|det)) else $error("irq without detect"); // R8

endmodule

// File: tb/ext_irq_sense_ctrl_tb_top.sv
module ext_irq_sense_ctrl_tb_top;

    localparam int NL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pins = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [11:0] addr;
        string       tag;
    } item_t;
    item_t sb_q[$];
    logic  rd_pend = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ext_irq_sense_ctrl #(.NUM_LINES(NL), .NUM_WIN(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_i    (pins),
        .irq_o     (irq)
    );

    // Monitor: note a read captured at the edge, compare at the falling edge
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_pend) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: read data 0x%08h with no expected item", bus_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr 0x%03h: got 0x%08h expected 0x%08h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Driver: issue a read and push the expected value onto the scoreboard
    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq_o: got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 50000);
        failures++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        report();
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        check_irq(1'b0, "R1");
        bus_read(12'h000, 32'h0, "R1");
        bus_read(12'h004, 32'h0, "R1");
        bus_read(12'h100, 32'h0, "R1");
        bus_read(12'h180, 32'h0, "R1");

        // R2: only bits [5:0] kept; R11: unmapped and unaligned read 0
        bus_write(12'h18C, 32'hFFFF_FFC8);
        bus_read(12'h18C, 32'h0000_0008, "R2");
        bus_read(12'h020, 32'h0, "R11");
        bus_read(12'h18D, 32'h0, "R11");

        // R3: rising edge on line 3 latched, not yet enabled
        pins[3] = 1'b1; wait_cyc(4);
        bus_read(12'h100, 32'h0000_0008, "R3");
        check_irq(1'b0, "R8");
        bus_read(12'h000, 32'h0, "R8");
        bus_write(12'h100, 32'h0000_0008);
        pins[3] = 1'b0; wait_cyc(4);
        bus_read(12'h100, 32'h0, "R3");

        // R7/R8: enable line 3 and take a new rising edge
        bus_write(12'h008, 32'h0000_0008);
        bus_read(12'h004, 32'h0000_0008, "R7");
        bus_read(12'h008, 32'h0, "R7");
        pins[3] = 1'b1; wait_cyc(4);
        bus_read(12'h000, 32'h0000_0008, "R8");
        check_irq(1'b1, "R8");

        // R6: writing zeros has no effect, writing one clears
        bus_write(12'h100, 32'hFFFF_FFF7);
        bus_read(12'h100, 32'h0000_0008, "R6");
        bus_write(12'h100, 32'h0000_0008);
        bus_read(12'h100, 32'h0, "R6");
        check_irq(1'b0, "R6");

        // R5: only reserved sense bits set on line 9
        bus_write(12'h1A4, 32'h0000_0030);
        bus_read(12'h1A4, 32'h0000_0030, "R2");
        pins[9] = 1'b1; wait_cyc(4);
        pins[9] = 1'b0; wait_cyc(4);
        bus_read(12'h100, 32'h0, "R5");

        // R3: falling edge on line 5
        bus_write(12'h194, 32'h0000_0004);
        pins[5] = 1'b1; wait_cyc(4);
        bus_read(12'h100, 32'h0, "R3");
        pins[5] = 1'b0; wait_cyc(4);
        bus_read(12'h100, 32'h0000_0020, "R3");
        bus_write(12'h100, 32'h0000_0020);

        // R3: both edges on line 6
        bus_write(12'h198, 32'h0000_000C);
        pins[6] = 1'b1; wait_cyc(4);
        bus_read(12'h100, 32'h0000_0040, "R3");
        bus_write(12'h100, 32'h0000_0040);
        pins[6] = 1'b0; wait_cyc(4);
        bus_read(12'h100, 32'h0000_0040, "R3");
        bus_write(12'h100, 32'h0000_0040);
        bus_read(12'h100, 32'h0, "R3");

        // R4: high level on line 7 persists through a clear
        bus_write(12'h19C, 32'h0000_0002);
        pins[7] = 1'b1; wait_cyc(4);
        bus_write(12'h100, 32'h0000_0080);
        bus_read(12'h100, 32'h0000_0080, "R4");
        pins[7] = 1'b0; wait_cyc(4);
        bus_write(12'h100, 32'h0000_0080);
        bus_read(12'h100, 32'h0, "R4");

        // R4: low level on line 8
        pins[8] = 1'b1; wait_cyc(4);
        bus_write(12'h1A0, 32'h0000_0001);
        wait_cyc(2);
        bus_read(12'h100, 32'h0, "R4");
        pins[8] = 1'b0; wait_cyc(4);
        bus_read(12'h100, 32'h0000_0100, "R4");
        pins[8] = 1'b1; wait_cyc(4);
        bus_write(12'h100, 32'h0000_0100);
        bus_read(12'h100, 32'h0, "R4");

        // R9: second window shares enables and request status
        bus_write(12'h018, 32'h0000_0080);
        bus_read(12'h004, 32'h0000_0088, "R9");
        bus_read(12'h014, 32'h0000_0088, "R9");
        pins[7] = 1'b1; wait_cyc(4);
        bus_read(12'h010, 32'h0000_0080, "R9");
        bus_read(12'h000, 32'h0000_0080, "R9");
        check_irq(1'b1, "R9");
        bus_write(12'h014, 32'h0000_0080);
        bus_read(12'h004, 32'h0000_0008, "R7");
        check_irq(1'b0, "R8");
        bus_read(12'h000, 32'h0, "R8");
        pins[7] = 1'b0; wait_cyc(4);
        bus_write(12'h100, 32'h0000_0080);

        // R10: monitor shows synchronised pin levels
        pins[20] = 1'b1; pins[31] = 1'b1; wait_cyc(3);
        bus_read(12'h104, 32'h8010_0108, "R10");

        // R6: clear and rising-edge event in the same cycle, set wins
        pins[3] = 1'b0; wait_cyc(4);
        bus_read(12'h100, 32'h0, "R3");
        pins[3] = 1'b1; wait_cyc(2);
        bus_write(12'h100, 32'h0000_0008);
        bus_read(12'h100, 32'h0000_0008, "R6");
        check_irq(1'b1, "R6");
        bus_write(12'h100, 32'h0000_0008);
        // R6: clear one cycle after the event removes it
        pins[3] = 1'b0; wait_cyc(4);
        pins[3] = 1'b1; wait_cyc(3);
        bus_write(12'h100, 32'h0000_0008);
        bus_read(12'h100, 32'h0, "R6");

        // R7: clear the remaining enable
        bus_write(12'h004, 32'h0000_0008);
        bus_read(12'h004, 32'h0, "R7");
        check_irq(1'b0, "R7");

        wait_cyc(3);
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d pending items expected 0", sb_q.size());
        end
        report();
    end

endmodule